// File: doc/BRIEF.md
# Break-Framed Serial Channel Transmitter

This block drives one serial output line with frames of lighting channel data. While idle the line rests high. The block checks a host-owned ready flag at a fixed polling interval. When it finds the flag set, it pulses a clear strobe so the host drops the flag. It then sends a low break, a high mark-after-break, a zero start byte and a programmed number of channel bytes. The channel bytes are fetched in ascending address order from an external byte buffer.

Every byte goes out as an asynchronous character: one low start bit, eight data bits sent least significant bit first, and two high stop bits. A mode input selects one of two bit periods: 4 µs for the standard lighting link or 1 µs for the faster headerless variant. All durations are whole multiples of the clock period and are derived from a clock frequency parameter. The mode and the channel count are captured when a request is accepted. They then hold for the whole frame.

Top module: `ftx_frame_tx`

## Requirements
- R1: Out of reset and between frames, `tx_out` is 1, `busy` is 0 and `ready_clr` is 0.
- R2: `ready_in` is examined only once every 400 µs of idle time (400·CLK_HZ/1e6 cycles). The first examination falls that many cycles after reset. When a request is pending, `busy` stays low for exactly that many cycles after the previous frame ends.
- R3: On acceptance, `busy` rises and `ready_clr` is 1 for exactly one cycle, which is the first cycle of the break.
- R4: The break holds `tx_out` low for 92 µs. The mark-after-break that follows holds it high for 12 µs.
- R5: Each character is a 0 start bit, data bits 0 through 7 in that order, and two 1 stop bits. A character starts in the cycle right after the previous one's last stop bit.
- R6: The bit period is 4 µs when `mode_fast` is 0 and 1 µs when it is 1.
- R7: The first character carries 0x00. It is followed by `chan_count` characters carrying buffer bytes from addresses 0, 1, 2 and onward, fetched through `rd_addr`/`rd_data`.
- R8: A `chan_count` of 0 sends the break, the mark-after-break and the zero start character only.
- R9: `busy` falls in the cycle right after the last stop bit of the frame ends, and `tx_out` is then 1.
- R10: Changes to `mode_fast` and `chan_count` while `busy` is 1 have no effect on the frame in progress.
- R11: A `ready_in` raised while a frame is being sent is not cleared by that frame. It is accepted at the first poll after the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fast | input | 1 | 0: 4 µs bit period, 1: 1 µs bit period |
| chan_count | input | CNT_W | Number of channel bytes after the start byte |
| ready_in | input | 1 | Host ready flag, level |
| ready_clr | output | 1 | One-cycle strobe telling the host to clear its flag |
| rd_addr | output | CNT_W | Buffer byte address |
| rd_data | input | 8 | Buffer byte at `rd_addr`, combinational read |
| busy | output | 1 | High from acceptance until the frame has ended |
| tx_out | output | 1 | Serial line, idle high |

## Verification
The bench uses a 4 MHz timing configuration. It measures the break and mark-after-break to the exact cycle, and it decodes every character at its bit centres in both modes for channel counts from 0 up to several bytes. A design with an off-by-one in a period counter would show a break or mark length one cycle off. A design using the wrong bit period would decode garbled data. A design that let the count or mode change mid-frame would end the frame at the wrong place. The bench raises the flag during a frame and expects the idle gap before the next frame to be exactly one polling interval; a design that cleared that flag, or polled out of step, would fail the gap measurement. A zero count is checked to end right after the start character, and the first character after each break must carry zero.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BREAK = 2'd1,
        ST_MAB   = 2'd2,
        ST_CHAR  = 2'd3
    } ftx_state_e;

    localparam int CHAR_BITS = 11;

    function automatic int us_cycles(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/ftx_period_timer.sv
module ftx_period_timer #(
    parameter int TW   = 17,
    parameter int INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= TW'(INIT);
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ftx_char_ser.sv
module ftx_char_ser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    input  logic       shift,
    output logic       bit_o,
    output logic       last_o
);
    import ftx_pkg::*;

    localparam int PW = $clog2(CHAR_BITS);

    typedef struct packed {
        logic [CHAR_BITS-1:0] sh;
        logic [PW-1:0]        pos;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh  = {2'b11, data, 1'b0};
            s_d.pos = '0;
        end else if (shift) begin
            s_d.sh  = {1'b1, s_q.sh[CHAR_BITS-1:1]};
            s_d.pos = s_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sh  <= '1;
            s_q.pos <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_o  = s_q.sh[0];
    assign last_o = (s_q.pos == PW'(CHAR_BITS - 1));

    // R5: a freshly loaded character begins with a low start bit
    a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !bit_o);

    // R5: the final bit slot of a character is a high stop bit
    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> bit_o);

endmodule

// File: rtl/ftx_seq.sv
module ftx_seq #(
    parameter int CNT_W    = 12,
    parameter int TW       = 17,
    parameter int BRK_CYC  = 18400,
    parameter int MAB_CYC  = 2400,
    parameter int SLOW_CYC = 800,
    parameter int FAST_CYC = 200,
    parameter int POLL_CYC = 80000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fast,
    input  logic [CNT_W-1:0] chan_count,
    input  logic             ready_in,
    input  logic [7:0]       rd_data,
    input  logic             tmr_zero,
    input  logic             ser_bit,
    input  logic             ser_last,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             ser_load,
    output logic [7:0]       ser_data,
    output logic             ser_shift,
    output logic [CNT_W-1:0] rd_addr,
    output logic             ready_clr,
    output logic             busy,
    output logic             tx_out
);
    import ftx_pkg::*;

    localparam logic [TW-1:0] BRK_LD  = TW'(BRK_CYC - 1);
    localparam logic [TW-1:0] MAB_LD  = TW'(MAB_CYC - 1);
    localparam logic [TW-1:0] SLOW_LD = TW'(SLOW_CYC - 1);
    localparam logic [TW-1:0] FAST_LD = TW'(FAST_CYC - 1);
    localparam logic [TW-1:0] POLL_LD = TW'(POLL_CYC - 1);

    typedef struct packed {
        ftx_state_e       st;
        logic             fast;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
        logic             clr;
    } seq_t;

    seq_t r_d, r_q;
    logic [TW-1:0] bit_ld;

    assign bit_ld = r_q.fast ? FAST_LD : SLOW_LD;

    always_comb begin
        r_d       = r_q;
        r_d.clr   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ser_load  = 1'b0;
        ser_data  = '0;
        ser_shift = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (ready_in) begin
                        r_d.st   = ST_BREAK;
                        r_d.fast = mode_fast;
                        r_d.cnt  = chan_count;
                        r_d.idx  = '0;
                        r_d.clr  = 1'b1;
                        tmr_val  = BRK_LD;
                    end else begin
                        tmr_val  = POLL_LD;
                    end
                end
            end
            ST_BREAK: begin
                if (tmr_zero) begin
                    r_d.st   = ST_MAB;
                    tmr_load = 1'b1;
                    tmr_val  = MAB_LD;
                end
            end
            ST_MAB: begin
                if (tmr_zero) begin
                    r_d.st   = ST_CHAR;
                    ser_load = 1'b1;
                    ser_data = 8'h00;
                    tmr_load = 1'b1;
                    tmr_val  = bit_ld;
                end
            end
            ST_CHAR: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (ser_last) begin
                        if (r_q.idx == r_q.cnt) begin
                            r_d.st  = ST_IDLE;
                            tmr_val = POLL_LD;
                        end else begin
                            ser_load = 1'b1;
                            ser_data = rd_data;
                            r_d.idx  = r_q.idx + 1'b1;
                            tmr_val  = bit_ld;
                        end
                    end else begin
                        ser_shift = 1'b1;
                        tmr_val   = bit_ld;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.fast <= 1'b0;
            r_q.cnt  <= '0;
            r_q.idx  <= '0;
            r_q.clr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_BREAK: tx_out = 1'b0;
            ST_CHAR:  tx_out = ser_bit;
            default:  tx_out = 1'b1;
        endcase
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign ready_clr = r_q.clr;
    assign rd_addr   = r_q.idx;

    // R1: line rests high whenever no frame is in progress
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);

    // R2: a request is taken only when the poll interval has run out
    a_r2_poll_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tmr_zero) && $past(ready_in));

    // R3: the clear strobe accompanies the start of a frame and lasts one cycle
    a_r3_clr_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ready_clr);
    a_r3_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready_clr |=> !ready_clr);

    // R4: the frame opens with the line low
    a_r4_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_out);

    // R7: the buffer address never passes the captured count
    a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_addr <= r_q.cnt));

    // R10: captured mode and count hold for the whole frame
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(r_q.fast) && $stable(r_q.cnt));

endmodule

// File: rtl/ftx_frame_tx.sv
module ftx_frame_tx #(
    parameter int CLK_HZ = 200_000_000,
    parameter int CNT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fast,
    input  logic [CNT_W-1:0] chan_count,
    input  logic             ready_in,
    output logic             ready_clr,
    output logic [CNT_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             busy,
    output logic             tx_out
);
    import ftx_pkg::*;

    localparam int BRK_CYC  = us_cycles(CLK_HZ, 92);
    localparam int MAB_CYC  = us_cycles(CLK_HZ, 12);
    localparam int SLOW_CYC = us_cycles(CLK_HZ, 4);
    localparam int FAST_CYC = us_cycles(CLK_HZ, 1);
    localparam int POLL_CYC = us_cycles(CLK_HZ, 400);
    localparam int TW       = $clog2(POLL_CYC + 1);

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          ser_load, ser_shift, ser_bit, ser_last;
    logic [7:0]    ser_data;

    ftx_period_timer #(
        .TW   (TW),
        .INIT (POLL_CYC - 1)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ftx_char_ser u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ser_load),
        .data   (ser_data),
        .shift  (ser_shift),
        .bit_o  (ser_bit),
        .last_o (ser_last)
    );

    ftx_seq #(
        .CNT_W    (CNT_W),
        .TW       (TW),
        .BRK_CYC  (BRK_CYC),
        .MAB_CYC  (MAB_CYC),
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC),
        .POLL_CYC (POLL_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_fast  (mode_fast),
        .chan_count (chan_count),
        .ready_in   (ready_in),
        .rd_data    (rd_data),
        .tmr_zero   (tmr_zero),
        .ser_bit    (ser_bit),
        .ser_last   (ser_last),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ser_load   (ser_load),
        .ser_data   (ser_data),
        .ser_shift  (ser_shift),
        .rd_addr    (rd_addr),
        .ready_clr  (ready_clr),
        .busy       (busy),
        .tx_out     (tx_out)
    );

endmodule

// File: tb/sim_ftx_frame_tx.sv
`timescale 1ns/1ps
module sim_ftx_frame_tx;

    localparam int CLK_HZ = 4_000_000;
    localparam int CNT_W  = 4;
    localparam int CPU    = CLK_HZ / 1_000_000;
    localparam int BRK    = 92 * CPU;
    localparam int MAB    = 12 * CPU;
    localparam int SLOWB  = 4 * CPU;
    localparam int FASTB  = 1 * CPU;
    localparam int POLL   = 400 * CPU;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_fast = 1'b0;
    logic [CNT_W-1:0] chan_count = '0;
    logic             flag = 1'b0;
    logic             ready_clr, busy, tx_out;
    logic [CNT_W-1:0] rd_addr;
    logic [7:0]       rd_data;
    logic [7:0]       mem [16];

    int checks = 0;
    int fails  = 0;
    int clr_seen = 0;

    always #2.5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    ftx_frame_tx #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_fast  (mode_fast),
        .chan_count (chan_count),
        .ready_in   (flag),
        .ready_clr  (ready_clr),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .tx_out     (tx_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // host model: drop the flag when the strobe is seen
    task automatic tick();
        @(negedge clk);
        if (ready_clr) begin
            flag = 1'b0;
            clr_seen++;
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 16; i++) begin
            if (seed == 7)      mem[i] = (i % 2 == 0) ? 8'h55 : 8'hAA;
            else if (seed == 8) mem[i] = (i % 2 == 0) ? 8'h80 : 8'h01;
            else if (seed == 9) mem[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
            else                mem[i] = 8'((i * 53 + seed * 29 + 1) & 255);
        end
    endtask

    task automatic wait_busy(output int gap);
        gap = 0;
        while (!busy && gap < 4 * POLL) begin
            gap++;
            tick();
        end
    endtask

    // called at the first negedge where busy is seen high
    task automatic decode(input bit fast, input int n, input bit chg, input bit reraise);
        int c0, lo, hi, bw, off;
        logic [10:0] s;
        logic [7:0] expv;
        c0 = clr_seen;
        chk(ready_clr == 1'b1 && flag == 1'b0, "R3 strobe at frame start", int'(ready_clr), 1);
        if (chg) begin
            mode_fast  = !fast;
            chan_count = 4'd15;
        end
        lo = 0;
        while (tx_out == 1'b0 && lo < 2 * BRK) begin
            lo++;
            tick();
            if (reraise && lo == 3) flag = 1'b1;
        end
        chk(lo == BRK, "R4 break length", lo, BRK);
        chk(clr_seen == c0, "R3 strobe single cycle", clr_seen - c0, 0);
        hi = 0;
        while (tx_out == 1'b1 && hi < 2 * MAB) begin
            hi++;
            tick();
        end
        chk(hi == MAB, "R4 mark-after-break length", hi, MAB);
        bw = fast ? FASTB : SLOWB;
        for (int c = 0; c <= n; c++) begin
            expv = (c == 0) ? 8'h00 : mem[c-1];
            off = 0;
            for (int b = 0; b < 11; b++) begin
                while (off < b * bw + bw / 2) begin
                    tick();
                    off++;
                end
                s[b] = tx_out;
            end
            chk(s[0] == 1'b0, "R5 start bit", int'(s[0]), 0);
            chk(s[10:9] == 2'b11, "R5 stop bits", int'(s[10:9]), 3);
            chk(s[8:1] == expv, (c == 0) ? "R7 zero start byte" : "R6 R7 channel byte",
                int'(s[8:1]), int'(expv));
            while (off < 11 * bw - 1) begin
                tick();
                off++;
            end
            chk(busy && tx_out, "R9 busy through last stop bit", int'(busy), 1);
            tick();
            if (c == n) begin
                chk(!busy && tx_out, (n == 0) ? "R8 frame ends after start byte" : "R9 busy falls at end",
                    int'(busy), 0);
            end else begin
                chk(busy && !tx_out, "R5 next character follows at once", int'(tx_out), 0);
            end
        end
        if (reraise) chk(flag == 1'b1, "R11 flag kept across frame", int'(flag), 1);
        if (chg) begin
            mode_fast  = fast;
            chan_count = 4'(n);
        end
    endtask

    task automatic frame(input bit fast, input int n, input int seed, input bit chg);
        int g;
        mode_fast  = fast;
        chan_count = 4'(n);
        fill(seed);
        flag = 1'b1;
        wait_busy(g);
        chk(busy == 1'b1, "R2 request accepted", int'(busy), 1);
        decode(fast, n, chg, 1'b0);
    endtask

    initial begin
        #(160_000 * 5);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int g;
        fill(0);
        repeat (4) @(negedge clk);
        chk(tx_out == 1'b1, "R1 reset line high", int'(tx_out), 1);
        chk(busy == 1'b0, "R1 reset not busy", int'(busy), 0);
        chk(ready_clr == 1'b0, "R1 reset no strobe", int'(ready_clr), 0);
        // first poll after reset
        mode_fast  = 1'b1;
        chan_count = 4'd3;
        fill(1);
        flag  = 1'b1;
        rst_n = 1'b1;
        wait_busy(g);
        chk(g == POLL, "R2 first poll after reset", g, POLL);
        decode(1'b1, 3, 1'b0, 1'b0);
        // fast sweep over counts
        for (int n = 0; n <= 6; n++) frame(1'b1, n, n + 2, 1'b0);
        // slow mode cases
        frame(1'b0, 0, 3, 1'b0);
        frame(1'b0, 1, 7, 1'b0);
        frame(1'b0, 3, 8, 1'b0);
        frame(1'b1, 5, 9, 1'b0);
        // R10: configuration edits during a frame are ignored
        frame(1'b0, 4, 5, 1'b1);
        frame(1'b1, 2, 6, 1'b1);
        // R11: request raised mid-frame is serviced one poll interval later
        mode_fast  = 1'b1;
        chan_count = 4'd2;
        fill(4);
        flag = 1'b1;
        wait_busy(g);
        decode(1'b1, 2, 1'b0, 1'b1);
        wait_busy(g);
        chk(g == POLL, "R11 R2 idle gap before pending frame", g, POLL);
        decode(1'b1, 2, 1'b0, 1'b0);
        repeat (5) tick();
        chk(tx_out == 1'b1 && busy == 1'b0, "R1 idle after frames", int'(tx_out), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule